// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO with Threshold Flags

This block carries 36-bit words from one clock domain to an unrelated one through a 256-entry dual-port array. The producer side pushes a word on any rising edge of its clock when it raises `wr_en` and the block shows `wr_ready`. The consumer side never asks for the first word. Once a word has crossed, the block moves it into an output register by itself and raises `rd_valid`. Each later word is loaded into that register on the edge that consumes the current one.

Both sides carry a threshold flag. `wr_afull_n` in the producer domain warns that free space is running short. `rd_aempty_n` in the consumer domain warns that few words remain. The two threshold values come in on quasi-static inputs from a separate loader. Pointers cross between the domains as Gray codes one bit wider than the address, through synchronizer chains. A word parked in the output register has already left the array, so its slot is free. With no reads at all, the block therefore accepts one word more than the array depth.

Top module: `xfifo_fwft_dc`

## Requirements
- R1: A word is stored on a rising `wr_clk` edge only if `wr_en` and `wr_ready` are both high at that edge. A write attempted while `wr_ready` is low is dropped and never appears at the output.
- R2: While `rd_valid` is low, `rd_en` has no effect, and `rd_data` keeps the last word it presented.
- R3: With the default two synchronizer stages, a word written into an empty FIFO appears on `rd_data` with `rd_valid` high after the third rising `rd_clk` edge following the write edge. `rd_valid` is still low after the first two of those edges.
- R4: While `rd_valid` is high and `rd_en` is low, `rd_data` and `rd_valid` hold. A rising `rd_clk` edge with both high consumes the word. It loads the next word if one has crossed, and otherwise drops `rd_valid`.
- R5: Words leave in the order they were accepted, with no loss and no duplication, at any ratio of clock rates and enable duty.
- R6: The word in the output register does not occupy an array slot. With no reads, exactly DEPTH+1 words (257 by default) are accepted before `wr_ready` stays low. `wr_ready` is low only when the array holds DEPTH words.
- R7: Once settled, `rd_aempty_n` is low when the stored count, including the word in the output register, is at most `ae_level`, and high otherwise.
- R8: Once settled, `wr_afull_n` is low when the array count (the stored words minus the one in the output register) is at least DEPTH minus `af_level`, and high otherwise. Whenever `wr_ready` falls, `wr_afull_n` is low.
- R9: While `rst_n` is low: `wr_ready` is low, `rd_valid` is low, `rd_aempty_n` is low and `wr_afull_n` is high. After release, `wr_ready` is still low after the first rising `wr_clk` edge and high after the second.
- R10: Each pointer crosses between domains as a Gray code that changes in at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| rd_clk | input | 1 | Consumer clock, unrelated to `wr_clk` |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_en | input | 1 | Push request |
| wr_data | input | 36 | Word to push |
| af_level | input | 8 | Almost-full threshold, counted in free slots |
| wr_ready | output | 1 | High when the array can take a word |
| wr_afull_n | output | 1 | Low when free space is at or below the threshold |
| rd_en | input | 1 | Consume request for the word on `rd_data` |
| ae_level | input | 8 | Almost-empty threshold, counted in stored words |
| rd_data | output | 36 | Output register contents |
| rd_valid | output | 1 | High when `rd_data` holds an unconsumed word |
| rd_aempty_n | output | 1 | Low when stored words are at or below the threshold |

## Verification
On every cycle, the bound checker confirms four things. The output word holds while nothing is valid or nothing is requested. `rd_valid` only falls after a consume. A drop of `wr_ready` always comes with almost-full. Both crossing pointers move in single Gray steps. Other behaviour needs scenarios. The bench shows the third-edge latency of the first word. It shows the DEPTH+1 capacity and the dropped write at full. It shows flag values against arithmetic counts over a full fill and drain with two threshold settings, and data order under three rate mixes against a queue.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  localparam int unsigned XF_PTR_MAX = 16;

  function automatic logic [XF_PTR_MAX-1:0] xf_bin2gray(input logic [XF_PTR_MAX-1:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/xfifo_g2b.sv
module xfifo_g2b #(
  parameter int W = 9
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  assign bin[W-1] = gray[W-1];
  generate
    for (genvar i = W - 2; i >= 0; i--) begin : g_bit
      assign bin[i] = bin[i+1] ^ gray[i];
    end
  endgenerate
endmodule

// File: rtl/xfifo_wr_ctl.sv
module xfifo_wr_ctl
  import xfifo_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          wr_en,
  input  logic [AW:0]   rq_gray,
  input  logic [AW-1:0] af_level,
  output logic          wr_ready,
  output logic          wr_afull_n,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_CNT = PW'(1) << AW;

  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d, rbin, used, af_thr;
  logic          nfull_q, nfull_d, afn_q, afn_d;

  xfifo_g2b #(.W(PW)) u_rq_g2b (.gray(rq_gray), .bin(rbin));

  assign wr_ready = run & nfull_q;
  assign wr_fire  = wr_en & wr_ready;

  always_comb begin
    wbin_d  = wbin_q + PW'(wr_fire);
    wgray_d = PW'(xf_bin2gray(XF_PTR_MAX'(wbin_d)));
    used    = wbin_d - rbin;
    af_thr  = FULL_CNT - {1'b0, af_level};
    nfull_d = (used != FULL_CNT);
    afn_d   = (used < af_thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      nfull_q <= 1'b0;
      afn_q   <= 1'b1;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      nfull_q <= nfull_d;
      afn_q   <= afn_d;
    end
  end

  assign wr_afull_n = afn_q;
  assign waddr      = wbin_q[AW-1:0];
  assign wgray      = wgray_q;
endmodule

// File: rtl/xfifo_rd_ctl.sv
module xfifo_rd_ctl
  import xfifo_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          rd_en,
  input  logic [AW:0]   wq_gray,
  input  logic [AW-1:0] ae_level,
  output logic          rd_valid,
  output logic          rd_aempty_n,
  output logic          rd_load,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray
);
  localparam int PW = AW + 1;
  localparam int CW = AW + 2;

  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d, wbin;
  logic [CW-1:0] stored;
  logic          valid_q, valid_d, aen_q, aen_d, ram_has;

  xfifo_g2b #(.W(PW)) u_wq_g2b (.gray(wq_gray), .bin(wbin));

  always_comb begin
    ram_has = (wbin != rbin_q);
    rd_load = run & ram_has & (~valid_q | rd_en);
    valid_d = rd_load | (valid_q & ~rd_en);
    rbin_d  = rbin_q + PW'(rd_load);
    rgray_d = PW'(xf_bin2gray(XF_PTR_MAX'(rbin_d)));
    stored  = CW'(wbin - rbin_d) + CW'(valid_d);
    aen_d   = (stored > CW'(ae_level));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      valid_q <= 1'b0;
      aen_q   <= 1'b0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      valid_q <= valid_d;
      aen_q   <= aen_d;
    end
  end

  assign rd_valid    = valid_q;
  assign rd_aempty_n = aen_q;
  assign raddr       = rbin_q[AW-1:0];
  assign rgray       = rgray_q;
endmodule

// File: rtl/xfifo_fwft_dc.sv
module xfifo_fwft_dc #(
  parameter int DEPTH       = 256,
  parameter int WIDTH       = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     wr_clk,
  input  logic                     rd_clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic [$clog2(DEPTH)-1:0] af_level,
  output logic                     wr_ready,
  output logic                     wr_afull_n,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] ae_level,
  output logic [WIDTH-1:0]         rd_data,
  output logic                     rd_valid,
  output logic                     rd_aempty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          wr_run, rd_run, wr_fire, rd_load;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wq_gray, rq_gray;
  logic [WIDTH-1:0] mem [DEPTH];

  // reset release, one chain per domain
  xfifo_sync #(.W(1), .STAGES(2)) u_wr_run (
    .clk(wr_clk), .rst_n(rst_n), .d(1'b1), .q(wr_run));
  xfifo_sync #(.W(1), .STAGES(2)) u_rd_run (
    .clk(rd_clk), .rst_n(rst_n), .d(1'b1), .q(rd_run));

  // Gray pointer crossings
  xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wq_gray));
  xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rq_gray));

  xfifo_wr_ctl #(.AW(AW)) u_wr_ctl (
    .clk(wr_clk), .rst_n(rst_n), .run(wr_run), .wr_en(wr_en),
    .rq_gray(rq_gray), .af_level(af_level), .wr_ready(wr_ready),
    .wr_afull_n(wr_afull_n), .wr_fire(wr_fire), .waddr(waddr), .wgray(wgray));

  xfifo_rd_ctl #(.AW(AW)) u_rd_ctl (
    .clk(rd_clk), .rst_n(rst_n), .run(rd_run), .rd_en(rd_en),
    .wq_gray(wq_gray), .ae_level(ae_level), .rd_valid(rd_valid),
    .rd_aempty_n(rd_aempty_n), .rd_load(rd_load), .raddr(raddr), .rgray(rgray));

  always_ff @(posedge wr_clk) begin
    if (wr_fire) mem[waddr] <= wr_data;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_load) rd_data <= mem[raddr];
  end
endmodule

// File: rtl/xfifo_fwft_dc_chk.sv
module xfifo_fwft_dc_chk #(
  parameter int AW    = 8,
  parameter int WIDTH = 36
) (
  input logic             wr_clk,
  input logic             rd_clk,
  input logic             rst_n,
  input logic             wr_ready,
  input logic             wr_afull_n,
  input logic             rd_en,
  input logic             rd_valid,
  input logic [WIDTH-1:0] rd_data,
  input logic [AW:0]      wgray,
  input logic [AW:0]      rgray
);
  // R2
  rd_hold_idle_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_valid |=> (rd_valid || $stable(rd_data)));

  // R4
  rd_hold_noreq_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data)));

  // R4
  rd_drop_after_req_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $fell(rd_valid) |-> $past(rd_en));

  // R8
  full_has_afull_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $fell(wr_ready) |-> !wr_afull_n);

  // R10
  wgray_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R10
  rgray_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind xfifo_fwft_dc xfifo_fwft_dc_chk #(.AW(AW), .WIDTH(WIDTH)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_ready(wr_ready),
  .wr_afull_n(wr_afull_n), .rd_en(rd_en), .rd_valid(rd_valid),
  .rd_data(rd_data), .wgray(wgray), .rgray(rgray));

// File: tb/xfifo_fwft_dc_tb.sv
`timescale 1ns/1ps
module xfifo_fwft_dc_tb;
  localparam int DEPTH = 256;
  localparam int WIDTH = 36;

  logic             wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b1;
  logic             wr_en = 1'b0, rd_en = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [7:0]       af_level = 8'd7, ae_level = 8'd5;
  logic             wr_ready, wr_afull_n, rd_valid, rd_aempty_n;
  logic [WIDTH-1:0] rd_data;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [WIDTH-1:0] q[$];

  xfifo_fwft_dc u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .af_level(af_level), .wr_ready(wr_ready),
    .wr_afull_n(wr_afull_n), .rd_en(rd_en), .ae_level(ae_level),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_aempty_n(rd_aempty_n));

  always #5 wr_clk = ~wr_clk;
  initial begin
    #2.3;
    forever #6.5 rd_clk = ~rd_clk;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(posedge rd_clk);
    repeat (8) @(posedge wr_clk);
    #1;
  endtask

  task automatic push_one(input logic [WIDTH-1:0] d);
    @(negedge wr_clk);
    chk(wr_ready, "R1 ready before push", 64'(wr_ready), 64'd1);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge wr_clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic pop_one(input logic [WIDTH-1:0] exp);
    @(negedge rd_clk);
    chk(rd_valid, "R4 valid before pop", 64'(rd_valid), 64'd1);
    chk(rd_data == exp, "R5 popped word", 64'(rd_data), 64'(exp));
    rd_en = 1'b1;
    @(posedge rd_clk);
    #1 rd_en = 1'b0;
  endtask

  // flag expectations from the stored count n (output register included)
  task automatic chk_flags(input int n, input string phase);
    int ram = (n == 0) ? 0 : n - 1;
    chk(rd_aempty_n == (n > int'(ae_level)), {"R7 ", phase}, 64'(rd_aempty_n), 64'(n > int'(ae_level)));
    chk(wr_afull_n == !(ram >= DEPTH - int'(af_level)), {"R8 ", phase}, 64'(wr_afull_n),
        64'(!(ram >= DEPTH - int'(af_level))));
    chk(wr_ready == (ram != DEPTH), {"R6 ", phase}, 64'(wr_ready), 64'(ram != DEPTH));
    chk(rd_valid == (n > 0), {"R4 valid level ", phase}, 64'(rd_valid), 64'(n > 0));
  endtask

  task automatic stream(input int n, input int pw, input int pr);
    int got = 0;
    fork
      begin : writer
        int sent = 0;
        while (sent < n) begin
          @(negedge wr_clk);
          wr_en   = (($urandom % 100) < pw);
          wr_data = {4'(pw), 32'($urandom)};
          if (wr_en && wr_ready) begin
            q.push_back(wr_data);
            sent++;
          end
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
      end
      begin : reader
        while (got < n) begin
          @(negedge rd_clk);
          rd_en = (($urandom % 100) < pr);
          if (rd_en && rd_valid) begin
            // R5, R10: order across the Gray crossing
            chk(q.size() > 0 && rd_data == q[0], "R5 stream order", 64'(rd_data),
                64'(q.size() > 0 ? q[0] : '0));
            if (q.size() > 0) void'(q.pop_front());
            got++;
          end
        end
        @(negedge rd_clk);
        rd_en = 1'b0;
      end
    join
  endtask

  initial begin
    repeat (200000) @(posedge wr_clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [WIDTH-1:0] held;
    #1 rst_n = 1'b0;
    repeat (5) @(posedge rd_clk);
    #1;
    // R9 reset values
    chk(!wr_ready, "R9 wr_ready in reset", 64'(wr_ready), 64'd0);
    chk(!rd_valid, "R9 rd_valid in reset", 64'(rd_valid), 64'd0);
    chk(!rd_aempty_n, "R9 aempty in reset", 64'(rd_aempty_n), 64'd0);
    chk(wr_afull_n, "R9 afull in reset", 64'(wr_afull_n), 64'd1);
    @(negedge wr_clk);
    rst_n = 1'b1;
    @(posedge wr_clk); #1;
    chk(!wr_ready, "R9 ready after edge 1", 64'(wr_ready), 64'd0);
    @(posedge wr_clk); #1;
    chk(wr_ready, "R9 ready after edge 2", 64'(wr_ready), 64'd1);
    settle();
    chk_flags(0, "empty");

    // R3: third read edge after the write edge
    @(negedge wr_clk);
    wr_en = 1'b1;
    wr_data = 36'h3_1234_5678;
    @(posedge wr_clk);
    fork begin #1 wr_en = 1'b0; end join_none
    @(posedge rd_clk);
    @(posedge rd_clk); #1;
    chk(!rd_valid, "R3 valid low after 2 edges", 64'(rd_valid), 64'd0);
    @(posedge rd_clk); #1;
    chk(rd_valid, "R3 valid high after 3 edges", 64'(rd_valid), 64'd1);
    chk(rd_data == 36'h3_1234_5678, "R3 word loaded", 64'(rd_data), 64'h3_1234_5678);
    pop_one(36'h3_1234_5678);
    settle();

    // R2: requests while nothing valid are ignored
    held = rd_data;
    @(negedge rd_clk);
    rd_en = 1'b1;
    repeat (6) @(posedge rd_clk);
    #1 rd_en = 1'b0;
    chk(!rd_valid, "R2 valid stays low", 64'(rd_valid), 64'd0);
    chk(rd_data == held, "R2 data held", 64'(rd_data), 64'(held));

    // R4: hold without request, then consume in order
    push_one(36'hA_0000_0001);
    push_one(36'hA_0000_0002);
    settle();
    repeat (5) @(posedge rd_clk);
    #1;
    chk(rd_valid && rd_data == 36'hA_0000_0001, "R4 held without request", 64'(rd_data), 64'hA_0000_0001);
    pop_one(36'hA_0000_0001);
    pop_one(36'hA_0000_0002);
    settle();
    chk(!rd_valid, "R4 valid drops when drained", 64'(rd_valid), 64'd0);

    // R6, R7, R8: fill sweep with ae 5, af 7
    ae_level = 8'd5;
    af_level = 8'd7;
    for (int n = 1; n <= DEPTH + 1; n++) begin
      push_one(36'h5_0000_0000 | 36'(n));
      settle();
      chk_flags(n, "fill");
    end
    // R1: writes while not ready are dropped
    @(negedge wr_clk);
    wr_en = 1'b1;
    wr_data = 36'hB_AD00_0BAD;
    repeat (4) @(posedge wr_clk);
    #1 wr_en = 1'b0;
    settle();
    chk(!wr_ready, "R1 still full after dropped writes", 64'(wr_ready), 64'd0);

    // drain sweep with ae 200, af 1
    ae_level = 8'd200;
    af_level = 8'd1;
    settle();
    chk_flags(DEPTH + 1, "drain start");
    for (int n = 1; n <= DEPTH + 1; n++) begin
      pop_one(36'h5_0000_0000 | 36'(n));
      settle();
      chk_flags(DEPTH + 1 - n, "drain");
    end
    chk(!rd_valid, "R1 no dropped word appears", 64'(rd_valid), 64'd0);

    // R5: three rate mixes
    ae_level = 8'd5;
    af_level = 8'd7;
    stream(600, 90, 30);
    stream(600, 30, 90);
    stream(600, 70, 70);
    settle();
    chk(q.size() == 0 && !rd_valid, "R5 stream fully drained", 64'(q.size()), 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule